// File: doc/BRIEF.md
# Prioritized Interrupt Pending Controller

This block gathers interrupt sources into one pending register and one enable register that share a bit layout, and it presents a single request with the index of the winning source to a processor. There are three kinds of source:
- three external inputs that act on a rising edge;
- one external active-low level input, which ranks below them;
- a parameterised set of internal one-cycle event pulses, such as timer, fault and message events.

Software writes the enable register directly. It clears pending bits by writing ones to them.

A request is raised only when the global enable bit and the source's own enable bit are both set. The output index always names the lowest-numbered pending bit that is also enabled.

The block also covers start-up in the halted state. When the processor is held halted out of reset, the first rising edge on the third external input releases it. That edge is consumed and leaves no pending bit behind.

Top module: `irq_pend_ctrl`

## Requirements
- R1: Both registers use one layout: bit 0 is the global enable, bits 1..3 are edge inputs 1..3 (`ext_edge_in[0..2]`), bit 4 is the level input, and bits 5 and up are the internal events (`evt_pulse[k]` maps to bit 5+k). Bit 0 of the pending register always reads 0.
- R2: A rising edge on an edge input sets its pending bit three rising clock edges after the input changes. An input held high sets the bit once only.
- R3: While `ext_lvl_n` is low, bit 4 is set on every cycle, and a clear written during that time has no effect. Once the input has been high for two cycles, a clear takes effect.
- R4: An internal event pulse sets its pending bit at the next clock edge.
- R5: A write with `wr_sel`=0 clears each pending bit whose data bit is 1 and leaves the bits written with 0 unchanged. A write with `wr_sel`=1 replaces the enable register with `wr_data`.
- R6: A set event in the same cycle as a write-1 clear of the same bit wins, so the bit stays pending.
- R7: `irq_req` is high exactly when enable bit 0 is set and at least one of bits 1 and up is both pending and enabled.
- R8: `irq_idx` is the lowest-numbered bit (from 1 up) that is both pending and enabled, so the edge inputs beat the level input and the level input beats the events. `irq_idx` is 0 when there is no request.
- R9: `halted` resets to the value of `start_halted`. While it is high, the first rising edge on edge input 3 clears it and does not set pending bit 3. Later edges set bit 3 as normal. Once cleared, `halted` stays low until the next reset.
- R10: After reset, the pending register, the enable register and `irq_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_edge_in | input | 3 | Rising-edge external interrupts 1..3 (asynchronous) |
| ext_lvl_n | input | 1 | Active-low level external interrupt (asynchronous) |
| evt_pulse | input | NUM_EVT | Internal event pulses, synchronous |
| start_halted | input | 1 | Halted start-up select, sampled during reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: write-1-to-clear the pending register, 1: write the enable register |
| wr_data | input | W | Write data |
| pend_out | output | W | Pending register |
| en_out | output | W | Enable register |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_idx | output | IDX_W | Index of the winning source, 0 if none |
| halted | output | 1 | Processor held halted |

## Verification
The assertions assume three things about the inputs:
- reset is held for longer than the synchronizer depth, so that no stale edge survives into normal operation;
- the internal event pulses and the write strobe are synchronous to `clk`;
- pending bit 3 cannot already be set while the processor is halted.

The bench drives every input on the falling clock edge and holds edge inputs high for at least four cycles, so each edge passes through the synchronizer cleanly. Between test vectors it releases every source and waits out the synchronizer before it clears, so that no vector inherits pending state from the one before.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int GIE_BIT   = 0;
    localparam int NUM_EDGE  = 3;
    localparam int LVL_BIT   = 4;
    localparam int FIRST_EVT = 5;
    localparam logic SEL_PEND = 1'b0;
    localparam logic SEL_EN   = 1'b1;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int WIDTH = 9,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] req_vec,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 1; i--) begin
            if (req_vec[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_EVT = 4,
    parameter int SYNC_STAGES = 2,
    localparam int W = FIRST_EVT + NUM_EVT,
    localparam int IDX_W = $clog2(W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EDGE-1:0] ext_edge_in,
    input  logic               ext_lvl_n,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               start_halted,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [W-1:0]       wr_data,
    output logic [W-1:0]       pend_out,
    output logic [W-1:0]       en_out,
    output logic               irq_req,
    output logic [IDX_W-1:0]   irq_idx,
    output logic               halted
);
    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] en;
        logic         halted;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    logic [NUM_EDGE:0]   sync_s;
    logic [NUM_EDGE-1:0] rise_s;
    logic                lvl_act_s;
    logic [W-1:0]        set_vec, clr_vec, live_vec, low_mask;
    logic                enc_valid;

    irq_sync #(
        .WIDTH(NUM_EDGE + 1),
        .STAGES(SYNC_STAGES),
        .RST_VAL({1'b1, {NUM_EDGE{1'b0}}})
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .din({ext_lvl_n, ext_edge_in}),
        .dout(sync_s)
    );

    irq_edge_det #(.WIDTH(NUM_EDGE)) u_edge (
        .clk(clk),
        .rst(rst),
        .lvl(sync_s[NUM_EDGE-1:0]),
        .rise(rise_s)
    );

    assign lvl_act_s = ~sync_s[NUM_EDGE];

    always_comb begin
        nxt_d   = cur_q;
        set_vec = '0;
        for (int i = 0; i < NUM_EDGE; i++) set_vec[i+1] = rise_s[i];
        if (cur_q.halted && rise_s[NUM_EDGE-1]) begin
            set_vec[NUM_EDGE] = 1'b0;
            nxt_d.halted      = 1'b0;
        end
        set_vec[LVL_BIT]            = lvl_act_s;
        set_vec[W-1:FIRST_EVT]      = evt_pulse;
        clr_vec = (wr_en && wr_sel == SEL_PEND) ? wr_data : '0;
        clr_vec[GIE_BIT] = 1'b0;
        nxt_d.pend = (cur_q.pend & ~clr_vec) | set_vec;
        if (wr_en && wr_sel == SEL_EN) nxt_d.en = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.pend   <= '0;
            cur_q.en     <= '0;
            cur_q.halted <= start_halted;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        live_vec = cur_q.pend & cur_q.en & {W{cur_q.en[GIE_BIT]}};
        live_vec[GIE_BIT] = 1'b0;
    end

    irq_prio_enc #(.WIDTH(W)) u_enc (
        .req_vec(live_vec),
        .valid(enc_valid),
        .idx(irq_idx)
    );

    assign irq_req  = enc_valid;
    assign pend_out = cur_q.pend;
    assign en_out   = cur_q.en;
    assign halted   = cur_q.halted;

    assign low_mask = ((W'(1) << irq_idx) - W'(1)) & ~W'(1);

    // R2
    edge_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
        rise_s[0] |=> cur_q.pend[1]);
    // R3
    lvl_holds_pend_chk: assert property (@(posedge clk) disable iff (rst)
        lvl_act_s |=> cur_q.pend[LVL_BIT]);
    // R5
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_PEND && wr_data[FIRST_EVT] && !evt_pulse[0])
        |=> !cur_q.pend[FIRST_EVT]);
    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse[0] && wr_en && wr_sel == SEL_PEND && wr_data[FIRST_EVT])
        |=> cur_q.pend[FIRST_EVT]);
    // R7
    req_needs_gie_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> cur_q.en[GIE_BIT]);
    // R8
    idx_is_live_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (cur_q.pend[irq_idx] && cur_q.en[irq_idx] && irq_idx != '0));
    // R8
    idx_is_highest_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ((cur_q.pend & cur_q.en & low_mask) == '0));
    // R9
    halt_release_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.halted && rise_s[NUM_EDGE-1]) |=> (!cur_q.halted && !cur_q.pend[NUM_EDGE]));
    // R9
    halt_no_reentry_chk: assert property (@(posedge clk) disable iff (rst)
        !cur_q.halted |=> !cur_q.halted);
endmodule

// File: tb/sim_irq_pend_ctrl.sv
module sim_irq_pend_ctrl;
    localparam int NUM_EVT = 4;
    localparam int W = 5 + NUM_EVT;
    localparam int IDX_W = $clog2(W);
    localparam int NV = 9;

    // fields: ext[21:19] lvl[18] evt[17:14] en[13:5] req[4] idx[3:0]
    localparam logic [21:0] VEC [NV] = '{
        {3'b111, 1'b0, 4'b0000, 9'h1FF, 1'b1, 4'd1},
        {3'b110, 1'b0, 4'b0000, 9'h1FF, 1'b1, 4'd2},
        {3'b100, 1'b1, 4'b0000, 9'h1FF, 1'b1, 4'd3},
        {3'b000, 1'b1, 4'b0001, 9'h1FF, 1'b1, 4'd4},
        {3'b000, 1'b0, 4'b1010, 9'h1FF, 1'b1, 4'd6},
        {3'b001, 1'b0, 4'b0001, 9'h1FD, 1'b1, 4'd5},
        {3'b001, 1'b0, 4'b0000, 9'h1FE, 1'b0, 4'd0},
        {3'b000, 1'b0, 4'b0000, 9'h1FF, 1'b0, 4'd0},
        {3'b000, 1'b1, 4'b1000, 9'h1EF, 1'b1, 4'd8}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] ext_edge_in = '0;
    logic ext_lvl_n = 1'b1;
    logic [NUM_EVT-1:0] evt_pulse = '0;
    logic start_halted = 1'b0;
    logic wr_en = 1'b0;
    logic wr_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] pend_out, en_out;
    logic irq_req;
    logic [IDX_W-1:0] irq_idx;
    logic halted;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [21:0] v;

    always #10 clk = ~clk;

    irq_pend_ctrl #(.NUM_EVT(NUM_EVT)) u0 (
        .clk(clk), .rst(rst), .ext_edge_in(ext_edge_in), .ext_lvl_n(ext_lvl_n),
        .evt_pulse(evt_pulse), .start_halted(start_halted), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .pend_out(pend_out), .en_out(en_out),
        .irq_req(irq_req), .irq_idx(irq_idx), .halted(halted)
    );

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic sel, logic [W-1:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(4);
        rst = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick();
        // R9 halted start-up
        start_halted = 1'b1;
        do_reset();
        check("R9 halted after reset", halted, 1);
        check("R10 pend after reset", pend_out, 0);
        ext_edge_in[2] = 1'b1; tick(4);
        check("R9 released by edge 3", halted, 0);
        check("R9 bit3 not set on release", pend_out[3], 0);
        ext_edge_in[2] = 1'b0; tick(3);
        ext_edge_in[2] = 1'b1; tick(4);
        check("R9 later edge sets bit3", pend_out[3], 1);
        check("R9 stays released", halted, 0);
        ext_edge_in[2] = 1'b0;

        // R10 normal reset
        start_halted = 1'b0;
        do_reset();
        check("R10 pend zero", pend_out, 0);
        check("R10 enable zero", en_out, 0);
        check("R10 no request", irq_req, 0);
        check("R9 not halted", halted, 0);

        // R2 exact latency and single set for held input
        ext_edge_in[0] = 1'b1;
        tick(2);
        check("R2 not yet after two edges", pend_out[1], 0);
        tick();
        check("R2 set after three edges", pend_out[1], 1);
        wr(1'b0, 9'h002);
        tick(3);
        check("R2 held high does not re-set", pend_out[1], 0);
        ext_edge_in[0] = 1'b0;
        tick(3);

        // R5 enable write, R1 global bit
        wr(1'b1, 9'h001);
        check("R5 enable write", en_out, 9'h001);
        check("R1 pend bit0 zero", pend_out[0], 0);

        // R4 event latency, R5 write-0 no effect
        evt_pulse[1] = 1'b1; tick(); evt_pulse = '0;
        check("R4 event sets bit6", pend_out[6], 1);
        wr(1'b0, 9'h000);
        check("R5 write 0 leaves bit6", pend_out[6], 1);
        wr(1'b0, 9'h040);
        check("R5 write 1 clears bit6", pend_out[6], 0);

        // R6 set wins over clear
        evt_pulse[0] = 1'b1;
        wr(1'b0, 9'h020);
        evt_pulse = '0;
        check("R6 set wins", pend_out[5], 1);
        wr(1'b0, 9'h020);
        check("R5 clear bit5", pend_out[5], 0);

        // R3 level behaviour
        ext_lvl_n = 1'b0; tick(4);
        check("R3 level sets bit4", pend_out[4], 1);
        wr(1'b0, 9'h010);
        check("R3 clear ignored while low", pend_out[4], 1);
        ext_lvl_n = 1'b1; tick(3);
        check("R3 still pending after release", pend_out[4], 1);
        wr(1'b0, 9'h010);
        check("R3 clear after release", pend_out[4], 0);

        // R7 R8 vector table
        for (int k = 0; k < NV; k++) begin
            v = VEC[k];
            wr(1'b1, v[13:5]);
            ext_edge_in = v[21:19];
            ext_lvl_n = ~v[18];
            evt_pulse = v[17:14];
            tick();
            evt_pulse = '0;
            tick(4);
            check("R7 request", irq_req, v[4]);
            check("R8 index", irq_idx, v[3:0]);
            ext_edge_in = '0;
            ext_lvl_n = 1'b1;
            tick(4);
            wr(1'b0, '1);
            check("R5 clear all", pend_out, 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule